// File: doc/BRIEF.md
# Dual-Modulus Divide-by-10/11 Prescaler

This block is a synchronous counter that divides its input clock by 10 or by 11. The choice comes from a small group of active-high ratio-select inputs. If any of them is high, the ratio is 10. If all of them are low, the ratio is 11. The counter steps through a ring of states. The ring has the base states plus one extra state, which is the eleventh. The extra state is visited only when the ratio-select group is low at the single decision edge of the cycle. So a division cycle always lasts exactly 10 or 11 input clocks, however the controls move during the cycle.

Two inputs override normal counting:

- A freeze input makes the counter keep its state on every clock edge.
- An asynchronous force input puts the counter straight into the eleventh state. While it is held, it drives all three outputs high, whatever the clock or the reset do.

The outputs are:

- the divided clock;
- its complement;
- a separate single-ended copy of the divided clock, for monitoring.

A typical use is as the fast front stage of a dual-modulus frequency synthesiser. A slower counter drives the ratio selects so that it swallows one extra input clock in chosen cycles.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With any ratio-select bit high (`mod_ctl` = 2'b01, 2'b10 or 2'b11) at the decision edge, the division cycle is 10 input clocks. This is measured between successive rising edges of `div_out`.
- R2: With every ratio-select bit low (`mod_ctl` = 2'b00, which is also the tied-off default), the division cycle is 11 input clocks.
- R3: The ratio-select inputs are sampled only at the rising clock edge that leaves the tenth state, which is four clocks after `div_out` is seen high. A pulse on a select at any other time has no effect, and every cycle is exactly 10 or 11 clocks long.
- R4: While `mset` is high, the counter is in the eleventh state at once, without waiting for a clock edge. `div_out`, `div_out_n` and `div_mon` are all high, and clock edges and `rst` have no effect.
- R5: While `hold` is high and `mset` is low, the count and the outputs stay unchanged on clock edges. Each held edge adds one clock to the current division cycle.
- R6: After `mset` falls, the first rising clock edge moves the counter to the first state, and `div_out` goes low. `div_out` then rises again on the sixth rising clock edge after the release.
- R7: A synchronous active-high `rst` puts the counter in the first state. In that state `div_out` = 0, `div_out_n` = 1 and `div_mon` = 0. `div_out` then rises five clocks after the reset edge.
- R8: The output is low for exactly 5 input clocks in each cycle. It is high for the remaining 5 clocks at ratio 10, or 6 clocks at ratio 11, so there is one fall and one rise per cycle.
- R9: While `mset` is low, `div_out_n` is the inverse of `div_out` and `div_mon` equals `div_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the first state |
| mset | input | 1 | Asynchronous active-high force to the eleventh state; all outputs high |
| hold | input | 1 | Active-high freeze of the count |
| mod_ctl | input | N_CTRL (2) | Ratio selects; any bit high gives divide by 10 |
| div_out | output | 1 | Divided clock |
| div_out_n | output | 1 | Complement of the divided clock |
| div_mon | output | 1 | Single-ended monitor copy of the divided clock |

## Verification
The cycle length is measured for each of the four settings of the two selects. This separates the OR combination from a single-input or AND decode. Select pulses placed on the decision state and next to it show whether the sampling point is the right one, rather than a level that is checked in every state. A freeze that lasts part of a cycle shows that the count holds rather than skips. The measured low time pins down the output decode. A force applied together with reset, and then released, shows that the force has priority and that counting restarts from the eleventh state.

// File: rtl/dmdiv_pkg.sv
package dmdiv_pkg;

    typedef enum logic [1:0] {
        STEP_ADVANCE = 2'd0,
        STEP_FREEZE  = 2'd1,
        STEP_WRAP    = 2'd2,
        STEP_EXTEND  = 2'd3
    } step_e;

    typedef struct packed {
        logic q;
        logic qn;
        logic mon;
    } div_outs_t;

    // Decide the move of the ring counter on the coming edge.
    function automatic step_e pick_step(
        input logic freeze,
        input logic at_decision,
        input logic at_extra,
        input logic want_ten
    );
        if (freeze)
            return STEP_FREEZE;
        if (at_extra)
            return STEP_WRAP;
        if (at_decision)
            return want_ten ? STEP_WRAP : STEP_EXTEND;
        return STEP_ADVANCE;
    endfunction

    function automatic div_outs_t drive_outs(
        input logic force_hi,
        input logic phase_hi
    );
        div_outs_t o;
        o.q   = force_hi | phase_hi;
        o.qn  = force_hi | ~phase_hi;
        o.mon = force_hi | phase_hi;
        return o;
    endfunction

endpackage

// File: rtl/dmdiv_mod_sel.sv
module dmdiv_mod_sel #(
    parameter int unsigned N_CTRL = 2
) (
    input  logic [N_CTRL-1:0] mod_ctl,
    output logic              want_ten
);
    // Any select high picks the shorter ratio; all low picks the longer one.
    assign want_ten = |mod_ctl;
endmodule

// File: rtl/dmdiv_core.sv
module dmdiv_core
    import dmdiv_pkg::*;
#(
    parameter int unsigned DIV_BASE = 10,
    localparam int unsigned STW = $clog2(DIV_BASE + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mset,
    input  logic           hold,
    input  logic           want_ten,
    output logic [STW-1:0] cnt,
    output logic           phase_hi
);
    localparam logic [STW-1:0] FIRST   = '0;
    localparam logic [STW-1:0] DECIDE  = STW'(DIV_BASE - 1);
    localparam logic [STW-1:0] EXTRA   = STW'(DIV_BASE);
    localparam logic [STW-1:0] HI_FROM = STW'(DIV_BASE / 2);

    step_e          step;
    logic [STW-1:0] nxt;

    assign step = pick_step(hold, cnt == DECIDE, cnt == EXTRA, want_ten);

    always_comb begin
        case (step)
            STEP_FREEZE: nxt = cnt;
            STEP_WRAP:   nxt = FIRST;
            STEP_EXTEND: nxt = EXTRA;
            default:     nxt = cnt + STW'(1);
        endcase
    end

    always_ff @(posedge clk or posedge mset) begin
        if (mset)
            cnt <= EXTRA;
        else if (rst)
            cnt <= FIRST;
        else
            cnt <= nxt;
    end

    assign phase_hi = (cnt >= HI_FROM);

    p_force_state_r4: assert property (@(posedge clk) mset |-> cnt == EXTRA);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst || mset)
        hold |=> $stable(cnt));

    p_decide_ten_r1: assert property (@(posedge clk) disable iff (rst || mset)
        (!hold && cnt == DECIDE && want_ten) |=> cnt == FIRST);

    p_decide_eleven_r2: assert property (@(posedge clk) disable iff (rst || mset)
        (!hold && cnt == DECIDE && !want_ten) |=> cnt == EXTRA);

    p_in_ring_r3: assert property (@(posedge clk) disable iff (rst || mset)
        cnt <= EXTRA);

    p_advance_r8: assert property (@(posedge clk) disable iff (rst || mset)
        (!hold && cnt < DECIDE) |=> cnt == $past(cnt) + STW'(1));

    p_reset_r7: assert property (@(posedge clk) disable iff (mset)
        rst |=> cnt == FIRST);
endmodule

// File: rtl/dmdiv_out.sv
module dmdiv_out
    import dmdiv_pkg::*;
(
    input  logic mset,
    input  logic phase_hi,
    output logic q,
    output logic qn,
    output logic mon
);
    div_outs_t o;

    assign o   = drive_outs(mset, phase_hi);
    assign q   = o.q;
    assign qn  = o.qn;
    assign mon = o.mon;
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int unsigned N_CTRL   = 2,
    parameter int unsigned DIV_BASE = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mset,
    input  logic              hold,
    input  logic [N_CTRL-1:0] mod_ctl,
    output logic              div_out,
    output logic              div_out_n,
    output logic              div_mon
);
    localparam int unsigned STW = $clog2(DIV_BASE + 1);

    logic           want_ten;
    logic [STW-1:0] cnt;
    logic           phase_hi;

    dmdiv_mod_sel #(.N_CTRL(N_CTRL)) u_sel (
        .mod_ctl  (mod_ctl),
        .want_ten (want_ten)
    );

    dmdiv_core #(.DIV_BASE(DIV_BASE)) u_core (
        .clk      (clk),
        .rst      (rst),
        .mset     (mset),
        .hold     (hold),
        .want_ten (want_ten),
        .cnt      (cnt),
        .phase_hi (phase_hi)
    );

    dmdiv_out u_out (
        .mset     (mset),
        .phase_hi (phase_hi),
        .q        (div_out),
        .qn       (div_out_n),
        .mon      (div_mon)
    );

    p_force_high_r4: assert property (@(posedge clk)
        mset |-> (div_out && div_out_n && div_mon));

    p_complement_r9: assert property (@(posedge clk) disable iff (mset)
        div_out_n != div_out);

    p_monitor_r9: assert property (@(posedge clk) disable iff (mset)
        div_mon == div_out);
endmodule

// File: tb/dual_mod_prescaler_test.sv
`timescale 1ns/1ps
module dual_mod_prescaler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mset = 1'b0;
    logic       hold = 1'b0;
    logic [1:0] mod_ctl = 2'b00;
    logic       div_out, div_out_n, div_mon;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 1'b0;

    always #2 clk = ~clk;

    dual_mod_prescaler #(.N_CTRL(2), .DIV_BASE(10)) uut (
        .clk(clk), .rst(rst), .mset(mset), .hold(hold), .mod_ctl(mod_ctl),
        .div_out(div_out), .div_out_n(div_out_n), .div_mon(div_mon)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until div_out is seen rising; -1 on timeout.
    task automatic wait_rise(output int n);
        logic p;
        p = div_out;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (div_out && !p) return;
            p = div_out;
        end
        n = -1;
    endtask

    task automatic t_reset_state();
        check(div_out == 1'b0, "R7 div_out", int'(div_out), 0);
        check(div_out_n == 1'b1, "R7 div_out_n", int'(div_out_n), 1);
        check(div_mon == 1'b0, "R7 div_mon", int'(div_mon), 0);
    endtask

    task automatic t_ratio(input logic [1:0] sel, input int exp, input string req);
        int n;
        mod_ctl = sel;
        wait_rise(n);
        wait_rise(n);
        wait_rise(n);
        check(n == exp, req, n, exp);
    endtask

    task automatic t_duty();
        int lo, hi;
        logic p;
        mod_ctl = 2'b00;
        wait_rise(lo);
        hi = 0;
        p = 1'b1;
        for (int i = 0; i < 50 && p; i++) begin
            @(negedge clk);
            hi++;
            p = div_out;
        end
        wait_rise(lo);
        check(hi == 6, "R8 high time at 11", hi, 6);
        check(lo == 5, "R8 low time", lo, 5);
    endtask

    // Pulse one select for one clock, starting at the given count after a rise.
    task automatic t_pulse(input int at, input int exp, input string req);
        int n;
        logic p;
        mod_ctl = 2'b00;
        wait_rise(n);
        p = 1'b1;
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            n++;
            if (div_out && !p) break;
            p = div_out;
            if (n == at) mod_ctl = 2'b10;
            if (n == at + 1) mod_ctl = 2'b00;
        end
        check(n == exp, req, n, exp);
    endtask

    task automatic t_hold();
        int n;
        logic p;
        logic seen;
        mod_ctl = 2'b00;
        wait_rise(n);
        p = 1'b1;
        n = 0;
        seen = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            n++;
            if (div_out && !p) break;
            p = div_out;
            if (hold && !div_out) seen = 1'b0;
            if (n == 2) hold = 1'b1;
            if (n == 9) hold = 1'b0;
        end
        check(seen, "R5 output held high", int'(seen), 1);
        check(n == 18, "R5 cycle with 7 held edges", n, 18);
    endtask

    task automatic t_pairs();
        bit ok_n, ok_m;
        ok_n = 1'b1;
        ok_m = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_out_n == div_out) ok_n = 1'b0;
            if (div_mon != div_out) ok_m = 1'b0;
        end
        check(ok_n, "R9 complement", int'(ok_n), 1);
        check(ok_m, "R9 monitor copy", int'(ok_m), 1);
    endtask

    task automatic t_force();
        int n;
        mod_ctl = 2'b00;
        wait_rise(n);
        @(negedge clk);
        @(negedge clk);
        mset = 1'b1;
        #0.5;
        check({div_out, div_out_n, div_mon} == 3'b111, "R4 async force high",
              int'({div_out, div_out_n, div_mon}), 7);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check({div_out, div_out_n, div_mon} == 3'b111, "R4 overrides clock and reset",
              int'({div_out, div_out_n, div_mon}), 7);
        rst = 1'b0;
        @(negedge clk);
        mset = 1'b0;
        #0.5;
        check(div_out == 1'b1 && div_out_n == 1'b0, "R6 eleventh state shows high",
              int'({div_out, div_out_n}), 2);
        @(negedge clk);
        check(div_out == 1'b0, "R6 low after first edge", int'(div_out), 0);
        wait_rise(n);
        check(n == 5, "R6 rise on sixth edge after release", n + 1, 6);
        wait_rise(n);
        check(n == 11, "R2 cycle after release", n, 11);
    endtask

    task automatic t_mid_reset();
        int n;
        wait_rise(n);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(div_out == 1'b0 && div_out_n == 1'b1, "R7 mid-run reset",
              int'({div_out, div_out_n}), 1);
        wait_rise(n);
        check(n == 5, "R7 rise after reset", n, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_ratio(2'b00, 11, "R2 both low");
        t_ratio(2'b01, 10, "R1 first select high");
        t_ratio(2'b10, 10, "R1 second select high");
        t_ratio(2'b11, 10, "R1 both high");
        t_ratio(2'b00, 11, "R2 back to both low");
        t_duty();
        t_pulse(4, 10, "R3 pulse on decision state");
        t_pulse(3, 11, "R3 pulse one state early");
        t_pulse(5, 11, "R3 pulse one state late");
        t_hold();
        t_pairs();
        t_force();
        t_mid_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule